// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block finds where one fixed-size entry of an in-memory translation table lives, given an integer identifier. The table is described by a 64-bit table-base word (base address, page size code, page count, indirect flag) plus an entry-size code. In flat mode the entry sits directly in a linear array. In indirect mode a first-level array of 8-byte pointers is read first. Each pointer, if marked valid, names a second-level page that holds the entries.

After a start pulse the walker issues its reads on a simple request/acknowledge memory port. It keeps at most one request in flight. It then reads or writes the final 64-bit entry. It reports the entry address, the data read, and a one-cycle done pulse with error and invalid status. It also gives, combinationally, the table capacity in entries for the configuration on its inputs.

Top module: `table_walker`

## Requirements
- R1: In flat mode (table word bit 62 = 0) the walk makes exactly one memory access, at base + id × 2^entLog2. The entry size in bytes is 2^entLog2, for entLog2 from 3 to 7. This address is shown on `entryAddr`.
- R2: In indirect mode (bit 62 = 1) the first access is a read at base + (id / (pageBytes / 8)) × 8.
- R3: If bit 63 of the first-level word read back is 0, the walk ends with `l1Invalid` = 1 and no second access.
- R4: If that bit is 1, the second access targets bits [50:0] of the first-level word + (id mod (pageBytes / 2^entLog2)) × 2^entLog2.
- R5: The page size code is table word bits [9:8]: 0 is 4 KB, 1 is 16 KB, 2 and 3 are 64 KB. For 4 KB and 16 KB pages the base is word bits [47:12] placed at address bit 12. For 64 KB pages, word bits [47:16] go to address bit 16 and word bits [15:12] go to address bits [51:48].
- R6: `capacity` equals (pages × pageBytes) / entryBytes when flat, and ((pages × pageBytes) / 8) × (pageBytes / entryBytes) when indirect. Pages is word bits [7:0] + 1.
- R7: An error response on any access ends the walk. `done` and `busErr` are high in the cycle after that response, and no further access is made.
- R8: With `opWrite` = 1 the final access is a write of `wrData` to the entry address. With `opWrite` = 0 the data returned by the final read appears on `rdData` at done.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start until done. A start while busy is ignored. `memReq` is never raised while an earlier request is unacknowledged.
- R10: After reset `busy`, `done`, `memReq`, `busErr` and `l1Invalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| opWrite | input | 1 | 1: write final entry, 0: read it |
| tableWord | input | 64 | Table-base word (base, page code, pages, indirect flag) |
| entLog2 | input | 3 | log2 of entry size in bytes |
| entryId | input | ID_W | Identifier to translate |
| wrData | input | 64 | Data for a write walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| busErr | output | 1 | Walk aborted by memory error |
| l1Invalid | output | 1 | First-level pointer was not valid |
| entryAddr | output | 52 | Final entry address |
| rdData | output | 64 | Entry read by a read walk |
| capacity | output | CAP_W | Entries the table can hold |
| memReq | output | 1 | One-cycle memory request strobe |
| memWe | output | 1 | Request is a write |
| memAddr | output | 52 | Request byte address |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | Response strobe |
| memErr | input | 1 | Response carries an error |
| memRdata | input | 64 | Little-endian read data |

## Verification
A start sampled at one edge raises `memReq` in the next cycle. Each request is acknowledged by the bench's memory model two cycles later. `done` rises in the cycle after the last acknowledgement, or the cycle after an error or invalid pointer. The bench drives stimulus and samples results on falling edges, waits for `done` and reads every walk result in that cycle. It also counts the requests the memory model saw, so it can tell how many accesses a walk made and which addresses they used. `capacity` is combinational and is sampled half a cycle after the inputs change.

// File: rtl/walker_pkg.sv
package walker_pkg;
  localparam int ADDR_W = 52;

  typedef struct packed {
    logic latchCmd;
    logic latchL1;
    logic latchRd;
    logic selL1;
    logic issue;
    logic setErr;
    logic setInv;
  } walkStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_ENT_REQ, S_ENT_WAIT, S_DONE
  } walkState_e;

  function automatic logic [4:0] pageLog2(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd12;
      2'd1:    return 5'd14;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/walker_ctrl.sv
module walker_ctrl
  import walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        indirectIn,
  input  logic        memAck,
  input  logic        memErr,
  input  logic        ptrValid,
  output walkStrobe_t strb,
  output logic        busy,
  output logic        done
);
  walkState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb = '0;
    case (state)
      S_IDLE: if (start) begin
        strb.latchCmd = 1'b1;
        nextState = indirectIn ? S_L1_REQ : S_ENT_REQ;
      end
      S_L1_REQ: begin
        strb.issue = 1'b1;
        strb.selL1 = 1'b1;
        nextState = S_L1_WAIT;
      end
      S_L1_WAIT: if (memAck) begin
        nextState = S_DONE;
        if (memErr) strb.setErr = 1'b1;
        else begin
          strb.latchL1 = 1'b1;
          if (ptrValid) nextState = S_ENT_REQ;
          else strb.setInv = 1'b1;
        end
      end
      S_ENT_REQ: begin
        strb.issue = 1'b1;
        nextState = S_ENT_WAIT;
      end
      S_ENT_WAIT: if (memAck) begin
        nextState = S_DONE;
        if (memErr) strb.setErr = 1'b1;
        else strb.latchRd = 1'b1;
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/walker_dp.sv
module walker_dp
  import walker_pkg::*;
#(
  parameter int ID_W  = 20,
  parameter int CAP_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic              opWrite,
  input  logic [63:0]       tableWord,
  input  logic [2:0]        entLog2,
  input  logic [ID_W-1:0]   entryId,
  input  logic [63:0]       wrData,
  input  logic [63:0]       memRdata,
  output logic              ptrValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [63:0]       memWdata,
  output logic [ADDR_W-1:0] entryAddr,
  output logic [63:0]       rdData,
  output logic              busErr,
  output logic              l1Invalid,
  output logic [CAP_W-1:0]  capacity
);
  localparam int PTR_W = 51;

  logic [63:0]       cfgQ, wrDataQ;
  logic [ID_W-1:0]   idQ;
  logic [2:0]        entQ;
  logic              opQ;
  logic [PTR_W-1:0]  ptrQ;

  // Base decode for the latched word and combinational capacity for the port word
  function automatic logic [ADDR_W-1:0] decodeBase(input logic [63:0] w);
    if (w[9:8] >= 2'd2) return {w[15:12], w[47:16], 16'h0};
    else                return {4'h0, w[47:12], 12'h0};
  endfunction

  logic [4:0] pgLogIn, pgLogQ;
  logic [5:0] capShift;
  assign pgLogIn  = pageLog2(tableWord[9:8]);
  assign capShift = tableWord[62] ? 6'(2 * pgLogIn - 5'd3 - 5'(entLog2))
                                  : 6'(pgLogIn - 5'(entLog2));
  assign capacity = (CAP_W'(tableWord[7:0]) + CAP_W'(1)) << capShift;

  assign pgLogQ = pageLog2(cfgQ[9:8]);

  logic [ADDR_W-1:0] baseQ, l1Addr, flatAddr, l2Addr, idMask;
  assign baseQ    = decodeBase(cfgQ);
  assign l1Addr   = baseQ + ((ADDR_W'(idQ) >> (pgLogQ - 5'd3)) << 3);
  assign flatAddr = baseQ + (ADDR_W'(idQ) << entQ);
  assign idMask   = (ADDR_W'(1) << (pgLogQ - 5'(entQ))) - ADDR_W'(1);
  assign l2Addr   = ADDR_W'(ptrQ) + ((ADDR_W'(idQ) & idMask) << entQ);
  assign entryAddr = cfgQ[62] ? l2Addr : flatAddr;

  assign memAddr  = strb.selL1 ? l1Addr : entryAddr;
  assign memWe    = strb.issue & ~strb.selL1 & opQ;
  assign memWdata = wrDataQ;
  assign ptrValid = memRdata[63];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0; wrDataQ <= '0; idQ <= '0; entQ <= '0; opQ <= 1'b0;
      ptrQ <= '0; rdData <= '0; busErr <= 1'b0; l1Invalid <= 1'b0;
    end else begin
      if (strb.latchCmd) begin
        cfgQ <= tableWord; wrDataQ <= wrData; idQ <= entryId;
        entQ <= entLog2; opQ <= opWrite; ptrQ <= '0;
        rdData <= '0; busErr <= 1'b0; l1Invalid <= 1'b0;
      end
      if (strb.latchL1) ptrQ <= memRdata[PTR_W-1:0];
      if (strb.latchRd && !opQ) rdData <= memRdata;
      if (strb.setErr) busErr <= 1'b1;
      if (strb.setInv) l1Invalid <= 1'b1;
    end
  end
endmodule

// File: rtl/table_walker.sv
module table_walker
  import walker_pkg::*;
#(
  parameter int ID_W  = 20,
  parameter int CAP_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opWrite,
  input  logic [63:0]       tableWord,
  input  logic [2:0]        entLog2,
  input  logic [ID_W-1:0]   entryId,
  input  logic [63:0]       wrData,
  output logic              busy,
  output logic              done,
  output logic              busErr,
  output logic              l1Invalid,
  output logic [ADDR_W-1:0] entryAddr,
  output logic [63:0]       rdData,
  output logic [CAP_W-1:0]  capacity,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  input  logic              memAck,
  input  logic              memErr,
  input  logic [63:0]       memRdata
);
  walkStrobe_t strb;
  logic ptrValid;

  walker_ctrl ctrl (
    .clk, .rstN, .start, .indirectIn(tableWord[62]), .memAck, .memErr,
    .ptrValid, .strb, .busy, .done
  );

  walker_dp #(.ID_W(ID_W), .CAP_W(CAP_W)) dp (
    .clk, .rstN, .strb, .opWrite, .tableWord, .entLog2, .entryId, .wrData,
    .memRdata, .ptrValid, .memAddr, .memWe, .memWdata, .entryAddr, .rdData,
    .busErr, .l1Invalid, .capacity
  );

  assign memReq = strb.issue;
endmodule

// File: rtl/table_walker_chk.sv
module table_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        busErr,
  input logic        l1Invalid,
  input logic        memReq,
  input logic        memAck,
  input logic        memErr,
  input logic [63:0] memRdata,
  input logic [63:0] tableWord
);
  logic       pending, walkInd;
  logic [1:0] walkReqs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0; walkInd <= 1'b0; walkReqs <= '0;
    end else begin
      if (memReq) pending <= 1'b1;
      else if (memAck) pending <= 1'b0;
      if (start && !busy) begin
        walkInd <= tableWord[62];
        walkReqs <= '0;
      end else if (memReq && walkReqs != 2'd3) walkReqs <= walkReqs + 2'd1;
    end
  end

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !pending);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  a_r7_err_abort: assert property (@(posedge clk) disable iff (!rstN)
    (memAck && memErr && busy) |=> (done && busErr && !memReq));
  a_r3_invalid_stop: assert property (@(posedge clk) disable iff (!rstN)
    (memAck && !memErr && busy && walkInd && walkReqs == 2'd1 && !memRdata[63])
      |=> (done && l1Invalid && !memReq));
  a_r1_flat_single: assert property (@(posedge clk) disable iff (!rstN)
    (done && !walkInd) |-> (walkReqs == 2'd1));
  a_r10_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && !memReq));
endmodule

bind table_walker table_walker_chk u_chk (
  .clk, .rstN, .start, .busy, .done, .busErr, .l1Invalid, .memReq,
  .memAck, .memErr, .memRdata, .tableWord
);

// File: tb/table_walker_test.sv
`timescale 1ns/1ps
module table_walker_test;
  localparam int ID_W = 20;
  localparam int CAP_W = 40;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic start = 0, opWrite = 0;
  logic [63:0] tableWord = '0, wrData = '0;
  logic [2:0] entLog2 = 3'd3;
  logic [ID_W-1:0] entryId = '0;
  logic busy, done, busErr, l1Invalid, memReq, memWe;
  logic [51:0] entryAddr, memAddr;
  logic [63:0] rdData, memWdata;
  logic [CAP_W-1:0] capacity;
  logic memAck, memErr;
  logic [63:0] memRdata;

  table_walker #(.ID_W(ID_W), .CAP_W(CAP_W)) uut (.*);

  // Memory model: acknowledges each request two cycles later
  logic [63:0] memArr [logic [51:0]];
  logic [51:0] errAddr = '1;
  logic [51:0] reqLog [0:7];
  int reqCnt = 0;
  logic pend = 0, pendErr = 0;
  logic [63:0] pendData = '0;
  int pendWait = 0;

  always @(posedge clk) begin
    memAck <= 1'b0;
    memErr <= 1'b0;
    if (pend) begin
      if (pendWait == 0) begin
        memAck <= 1'b1; memErr <= pendErr; memRdata <= pendData; pend <= 1'b0;
      end else pendWait <= pendWait - 1;
    end
    if (memReq) begin
      if (reqCnt < 8) reqLog[reqCnt] <= memAddr;
      reqCnt <= reqCnt + 1;
      pend <= 1'b1; pendWait <= 1;
      pendErr <= (memAddr == errAddr);
      pendData <= memArr.exists(memAddr) ? memArr[memAddr] : 64'h0;
      if (memWe) memArr[memAddr] = memWdata;
    end
  end

  int nChk = 0, nFail = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkWord(input logic [51:0] base, input logic [1:0] code,
                                         input logic [7:0] sz, input logic ind);
    logic [63:0] w;
    w = {1'b0, ind, 54'h0, sz};
    w[9:8] = code;
    if (code >= 2) begin
      w[47:16] = base[47:16];
      w[15:12] = base[51:48];
    end else w[47:12] = base[47:12];
    return w;
  endfunction

  task automatic runWalk(output bit ok);
    int t;
    reqCnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    t = 0; ok = 1;
    while (!done && t < 50) begin @(negedge clk); t++; end
    if (!done) begin ok = 0; nChk++; nFail++; $display("FAIL walk timeout"); end
  endtask

  task automatic testReset();
    chk("R10 busy", busy, 0); chk("R10 done", done, 0);
    chk("R10 memReq", memReq, 0); chk("R10 busErr", busErr, 0);
    chk("R10 l1Invalid", l1Invalid, 0);
  endtask

  task automatic testFlatRead();
    logic [51:0] base = 52'h0_0001_2345_6000, exp;
    bit ok;
    tableWord = mkWord(base, 2'd0, 8'd3, 1'b0); entLog2 = 3; entryId = 20'd5; opWrite = 0;
    exp = base + 5 * 8;
    memArr[exp] = 64'hDEAD_BEEF_0123_4567;
    runWalk(ok);
    chk("R1 flat addr", entryAddr, exp);
    chk("R1 flat count", reqCnt, 1);
    chk("R5 4K base", reqLog[0], exp);
    chk("R8 read data", rdData, 64'hDEAD_BEEF_0123_4567);
    chk("R7 no err", busErr, 0);
    @(negedge clk); chk("R9 done pulse", done, 0);
  endtask

  task automatic testFlatWrite();
    logic [51:0] base = 52'h0_00AB_CDE0_4000, exp;
    bit ok;
    tableWord = mkWord(base, 2'd1, 8'd0, 1'b0); entLog2 = 4; entryId = 20'h00321; opWrite = 1;
    wrData = 64'h1122_3344_5566_7788;
    exp = base + 20'h00321 * 16;
    runWalk(ok);
    chk("R1 16K flat addr", entryAddr, exp);
    chk("R8 write stored", memArr.exists(exp) ? memArr[exp] : 64'h0, 64'h1122_3344_5566_7788);
    chk("R8 write count", reqCnt, 1);
    opWrite = 0;
  endtask

  task automatic testIndirect();
    logic [51:0] base = 52'hA_0000_1234_0000, l1a, l2base = 52'h0_0000_7770_0000, exp;
    bit ok;
    tableWord = mkWord(base, 2'd2, 8'd1, 1'b1); entLog2 = 3; entryId = 20'h12345;
    l1a = base + (20'h12345 / (65536 / 8)) * 8;
    exp = l2base + (20'h12345 % (65536 / 8)) * 8;
    memArr[l1a] = {1'b1, 12'h0, l2base[50:0]};
    memArr[exp] = 64'hCAFE_F00D_0000_0042;
    runWalk(ok);
    chk("R2 l1 addr / R5 64K base", reqLog[0], l1a);
    chk("R4 l2 addr", reqLog[1], exp);
    chk("R4 entryAddr", entryAddr, exp);
    chk("R4 count", reqCnt, 2);
    chk("R8 indirect data", rdData, 64'hCAFE_F00D_0000_0042);
    chk("R3 valid ptr", l1Invalid, 0);
  endtask

  task automatic testInvalid();
    logic [51:0] base = 52'h0_0000_0055_0000, l1a;
    bit ok;
    tableWord = mkWord(base, 2'd0, 8'd0, 1'b1); entLog2 = 5; entryId = 20'h01234;
    l1a = base + (20'h01234 / 512) * 8;
    memArr[l1a] = 64'h0000_0000_0009_9000;
    runWalk(ok);
    chk("R3 invalid flag", l1Invalid, 1);
    chk("R3 single access", reqCnt, 1);
    chk("R3 l1 addr", reqLog[0], l1a);
  endtask

  task automatic testErrors();
    logic [51:0] base = 52'h0_0000_0066_0000, l1a;
    bit ok;
    tableWord = mkWord(base, 2'd1, 8'd0, 1'b1); entLog2 = 3; entryId = 20'h00010;
    l1a = base + (20'h00010 / 2048) * 8;
    errAddr = l1a;
    runWalk(ok);
    chk("R7 l1 err flag", busErr, 1);
    chk("R7 l1 err count", reqCnt, 1);
    tableWord = mkWord(base, 2'd0, 8'd0, 1'b0); entryId = 20'h00002;
    errAddr = base + 2 * 8;
    runWalk(ok);
    chk("R7 entry err flag", busErr, 1);
    errAddr = '1;
    runWalk(ok);
    chk("R7 err cleared", busErr, 0);
  endtask

  task automatic testCapacity();
    tableWord = mkWord(52'h0, 2'd0, 8'd3, 1'b0); entLog2 = 3;
    @(negedge clk); chk("R6 flat 4K", capacity, 40'((4 * 4096) / 8));
    tableWord = mkWord(52'h0, 2'd3, 8'd255, 1'b0); entLog2 = 7;
    @(negedge clk); chk("R6 flat 64K", capacity, 40'((longint'(256) * 65536) / 128));
    tableWord = mkWord(52'h0, 2'd1, 8'd1, 1'b1); entLog2 = 4;
    @(negedge clk); chk("R6 indirect 16K", capacity, 40'(((2 * 16384) / 8) * (16384 / 16)));
  endtask

  task automatic testBusyStart();
    logic [51:0] base = 52'h0_0000_0077_0000, exp;
    int t;
    tableWord = mkWord(base, 2'd0, 8'd0, 1'b0); entLog2 = 3; entryId = 20'd7;
    exp = base + 7 * 8;
    reqCnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; chk("R9 busy", busy, 1);
    entryId = 20'd9;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    t = 0;
    while (!done && t < 50) begin @(negedge clk); t++; end
    chk("R9 first id kept", entryAddr, exp);
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk("R9 start while busy ignored", reqCnt, 1);
    chk("R9 idle after", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    testFlatRead();
    testFlatWrite();
    testIndirect();
    testInvalid();
    testErrors();
    testCapacity();
    testBusyStart();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #200000;
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule